// File: doc/BRIEF.md
# DMA Event Status and Interrupt Register

This block records the events that several DMA channels share: a channel bus error, a breakpoint seen during a transfer, and a reserved test event. Each event is a one-cycle pulse. The pulse sets a sticky flag in an 8-bit status register. Software reads that register through a small register port and clears flags by writing ones to them. When a channel reports a bus error, it also presents the system address it was accessing. The block freezes that address into a read-only capture register, so software can find out where the fault happened.

A single level interrupt request is derived from the flags. Each flag is gated by its own enable input, and the combined request is then gated by a mask bit that comes from the upstream interrupt controller. The enables only affect the interrupt. They never stop a flag from being recorded.

Top module: `dma_evt_stat`

## Requirements
- R1: After reset the status register reads 0x00 and `irq` is low.
- R2: A pulse on `ev_brkpt`, `ev_buserr` or `ev_test` sets status bit 0, 1 or 2 respectively on the next clock edge, whatever the enable inputs are. The flag stays set until software clears it.
- R3: A write to offset `STAT_OFS` clears every status bit whose `wr_data` bit is one. Bits written with zero keep their value, and several bits can be cleared in one write.
- R4: If an event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R5: Status bits 7 to 3 always read as zero, and writing ones to them has no effect.
- R6: On the clock edge that samples `ev_buserr` high, `err_addr` is stored in the capture register. That register reads back at offset `CAP_OFS` and otherwise holds its value. Writes to `CAP_OFS` do not change it.
- R7: `irq` is high exactly when `irq_mask` is high and at least one status bit `i` (bits 0 to 2) is set together with its enable bit `irq_en[i]`. It falls in the cycle after the flags involved are cleared.
- R8: A read at any offset other than `STAT_OFS` or `CAP_OFS` returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | AW | Register offset for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data (ones clear status flags) |
| rd_data | output | CAP_W | Combinational read data for `reg_addr` |
| ev_brkpt | input | 1 | Breakpoint event pulse |
| ev_buserr | input | 1 | Bus-error event pulse |
| ev_test | input | 1 | Reserved test event pulse |
| err_addr | input | CAP_W | Faulting system address, valid with `ev_buserr` |
| irq_en | input | 3 | Per-flag interrupt enables (bit order as status) |
| irq_mask | input | 1 | Upstream DMA interrupt mask bit |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: a 32-bit capture width, a 4-bit offset, status at offset 0 and capture at offset 4. With a 4-bit offset, every unmapped offset can be tried, so the zero-read rule is checked on all of them. The 32-bit capture lets distinct address patterns show whether a stale address survives a later error. Directed phases hit set-versus-clear collisions, writes that target the reserved bits and the read-only capture register, and every enable and mask combination. A random phase then mixes events and writes on each cycle.

// File: rtl/dma_evt_stat.sv
module dma_evt_stat #(
  parameter int CAP_W    = 32,
  parameter int AW       = 4,
  parameter int STAT_OFS = 0,
  parameter int CAP_OFS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [CAP_W-1:0] rd_data,
  input  logic             ev_brkpt,
  input  logic             ev_buserr,
  input  logic             ev_test,
  input  logic [CAP_W-1:0] err_addr,
  input  logic [2:0]       irq_en,
  input  logic             irq_mask,
  output logic             irq
);
  localparam logic [7:0]    LIVE = 8'h07;
  localparam logic [AW-1:0] A_ST = AW'(STAT_OFS);
  localparam logic [AW-1:0] A_CP = AW'(CAP_OFS);

  logic [7:0]       stat_q;
  logic [CAP_W-1:0] cap_q;

  wire        hit_st = wr_en && (reg_addr == A_ST);
  wire  [7:0] clr    = hit_st ? (wr_data & LIVE) : 8'h00;
  wire  [7:0] set    = {5'b0, ev_test, ev_buserr, ev_brkpt};

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= 8'h00;
    else        stat_q <= ((stat_q & ~clr) | set) & LIVE;
  end

  always_ff @(posedge clk) begin
    if (ev_buserr) cap_q <= err_addr;
  end

  always_comb begin
    if (reg_addr == A_ST)      rd_data = CAP_W'(stat_q);
    else if (reg_addr == A_CP) rd_data = cap_q;
    else                       rd_data = '0;
  end

  assign irq = irq_mask && |(stat_q[2:0] & irq_en);
endmodule

module dma_evt_stat_chk #(
  parameter int CAP_W    = 32,
  parameter int AW       = 4,
  parameter int STAT_OFS = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    reg_addr,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             ev_brkpt,
  input logic             ev_buserr,
  input logic             ev_test,
  input logic [CAP_W-1:0] err_addr,
  input logic             irq_mask,
  input logic             irq,
  input logic [7:0]       stat_q,
  input logic [CAP_W-1:0] cap_q
);
  wire st_wr = wr_en && (reg_addr == AW'(STAT_OFS));

  // R2
  brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_brkpt |=> stat_q[0]);

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && wr_data[1] && !ev_buserr) |=> !stat_q[1]);

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && wr_data[2] && ev_test) |=> stat_q[2]);

  // R6
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buserr |=> (cap_q == $past(err_addr)));

  // R6
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_buserr |=> $stable(cap_q));

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !irq);

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q[2:0] != 3'b000));
endmodule

bind dma_evt_stat dma_evt_stat_chk #(.CAP_W(CAP_W), .AW(AW), .STAT_OFS(STAT_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
  .ev_brkpt(ev_brkpt), .ev_buserr(ev_buserr), .ev_test(ev_test), .err_addr(err_addr),
  .irq_mask(irq_mask), .irq(irq), .stat_q(stat_q), .cap_q(cap_q)
);

// File: tb/dma_evt_stat_test.sv
module dma_evt_stat_test;
  localparam int CW = 32;
  localparam int AW = 4;
  localparam int SO = 0;
  localparam int CO = 4;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] reg_addr = '0;
  logic wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [CW-1:0] rd_data;
  logic ev_brkpt = 0, ev_buserr = 0, ev_test = 0;
  logic [CW-1:0] err_addr = '0;
  logic [2:0] irq_en = '0;
  logic irq_mask = 0, irq;

  int n_chk = 0, n_bad = 0;
  int m_st = 0;
  logic [CW-1:0] m_cap = '0;
  bit cap_ok = 0;

  always #10 clk = ~clk;

  dma_evt_stat #(.CAP_W(CW), .AW(AW), .STAT_OFS(SO), .CAP_OFS(CO)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ev_brkpt(ev_brkpt), .ev_buserr(ev_buserr), .ev_test(ev_test),
    .err_addr(err_addr), .irq_en(irq_en), .irq_mask(irq_mask), .irq(irq));

  task automatic cyc(input string req, input logic [2:0] ev, input logic [CW-1:0] ea,
                     input logic we, input int a, input logic [7:0] wd,
                     input logic [2:0] ie, input logic m);
    logic [CW-1:0] exp_rd;
    logic exp_irq;
    bit do_rd;
    {ev_test, ev_buserr, ev_brkpt} = ev;
    err_addr = ea; wr_en = we; reg_addr = AW'(a); wr_data = wd;
    irq_en = ie; irq_mask = m;
    #1;
    do_rd = 1;
    if (a == SO)      exp_rd = CW'(m_st);
    else if (a == CO) begin exp_rd = m_cap; do_rd = cap_ok; end
    else              exp_rd = '0;
    exp_irq = m && ((m_st & int'(ie)) != 0);
    if (do_rd) begin
      n_chk++;
      if (rd_data !== exp_rd) begin
        n_bad++;
        $display("FAIL %s rd_data off=%0d actual=%h expected=%h", req, a, rd_data, exp_rd);
      end
    end
    n_chk++;
    if (irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, exp_irq);
    end
    @(posedge clk);
    if (!rst_n) m_st = 0;
    else begin
      if (we && a == SO) m_st = m_st & ~(int'(wd) & 7);
      m_st = m_st | int'(ev);
    end
    if (ev[1]) begin m_cap = ea; cap_ok = 1; end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst_n = 0;
    cyc("R1", 3'b000, '0, 0, SO, 8'h00, 3'b111, 1);
    rst_n = 1;
    // R1 status zero and irq low after reset
    cyc("R1", 3'b000, '0, 0, SO, 8'h00, 3'b111, 1);
    // R2 events set flags with all enables low
    cyc("R2", 3'b001, '0, 0, SO, 8'h00, 3'b000, 1);
    cyc("R2", 3'b100, '0, 0, SO, 8'h00, 3'b000, 1);
    cyc("R2", 3'b010, 32'hDEAD_BEEF, 0, SO, 8'h00, 3'b000, 1);
    cyc("R2", 3'b000, '0, 0, SO, 8'h00, 3'b000, 1);
    // R3 zero writes keep, single and multi clears
    cyc("R3", 3'b000, '0, 1, SO, 8'h00, 3'b000, 0);
    cyc("R3", 3'b000, '0, 1, SO, 8'h02, 3'b000, 0);
    cyc("R3", 3'b000, '0, 1, SO, 8'h05, 3'b000, 0);
    cyc("R3", 3'b000, '0, 0, SO, 8'h00, 3'b000, 0);
    // R4 event and clear on the same bit
    cyc("R4", 3'b111, 32'h1234_5678, 1, SO, 8'h07, 3'b000, 0);
    cyc("R4", 3'b000, '0, 0, SO, 8'h00, 3'b000, 0);
    cyc("R4", 3'b001, '0, 1, SO, 8'h07, 3'b000, 0);
    cyc("R4", 3'b000, '0, 0, SO, 8'h00, 3'b000, 0);
    // R5 reserved bits ignore writes and read zero
    cyc("R5", 3'b000, '0, 1, SO, 8'hF8, 3'b000, 0);
    cyc("R5", 3'b000, '0, 0, SO, 8'h00, 3'b000, 0);
    cyc("R5", 3'b000, '0, 1, SO, 8'hFF, 3'b000, 0);
    cyc("R5", 3'b000, '0, 0, SO, 8'h00, 3'b000, 0);
    // R6 capture, overwrite, hold, writes ignored
    cyc("R6", 3'b000, '0, 0, CO, 8'h00, 3'b000, 0);
    cyc("R6", 3'b010, 32'hA5A5_0001, 0, CO, 8'h00, 3'b000, 0);
    cyc("R6", 3'b000, 32'hFFFF_FFFF, 1, CO, 8'hFF, 3'b000, 0);
    cyc("R6", 3'b010, 32'h0F0F_F0F0, 0, CO, 8'h00, 3'b000, 0);
    cyc("R6", 3'b000, 32'h1111_1111, 1, CO, 8'h00, 3'b000, 0);
    cyc("R6", 3'b000, '0, 0, CO, 8'h00, 3'b000, 0);
    cyc("R6", 3'b000, '0, 1, SO, 8'h07, 3'b000, 0);
    // R7 enable and mask combinations
    cyc("R7", 3'b001, '0, 0, SO, 8'h00, 3'b000, 1);
    for (int e = 0; e < 8; e++) begin
      cyc("R7", 3'b000, '0, 0, SO, 8'h00, 3'(e), 1);
      cyc("R7", 3'b000, '0, 0, SO, 8'h00, 3'(e), 0);
    end
    cyc("R7", 3'b100, '0, 0, SO, 8'h00, 3'b100, 1);
    cyc("R7", 3'b000, '0, 1, SO, 8'h04, 3'b101, 1);
    cyc("R7", 3'b000, '0, 1, SO, 8'h01, 3'b101, 1);
    cyc("R7", 3'b000, '0, 0, SO, 8'h00, 3'b111, 1);
    // R8 all unmapped offsets read zero
    cyc("R8", 3'b111, 32'h7777_0000, 0, SO, 8'h00, 3'b000, 0);
    for (int a = 0; a < (1 << AW); a++)
      if (a != SO && a != CO) cyc("R8", 3'b000, '0, 0, a, 8'h00, 3'b000, 0);
    // R3 random mix of events and writes
    for (int i = 0; i < 400; i++) begin
      int a;
      a = ($urandom % 3 == 0) ? CO : (($urandom % 5 == 0) ? int'($urandom % 16) : SO);
      cyc("R3", 3'($urandom) & 3'($urandom), $urandom, 1'($urandom),
          a, 8'($urandom), 3'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule